// File: doc/BRIEF.md
# Reed-Solomon symbol error applier

This block takes the output of a Reed-Solomon error locator and applies it to a flash page held in an on-block byte RAM. The code word is made of 12-bit symbols packed back to back, most significant bit first, across a 2048-byte data area and the first bytes of the spare area that follows it. Symbol 0 is special: its top four bits fall before the start of the page, so only its low eight bits are real. The RAM holds the data area at addresses 0 to 2047 and spare byte k at address 2048+k. With that layout, one odd/even packing rule covers every symbol, including the one that straddles the data/spare boundary.

A host loads the page through a simple byte port, presents up to four (position, pattern) pairs and a count, and pulses start. The block walks the pairs in order. For each pair it works out the one or two bytes and the nibble alignment, and updates each byte with a read cycle followed by a write cycle. If a pair cannot be applied, the walk stops. The block then reports either the number of symbols it corrected or a failure flag, and the host reads the corrected page back through the same port.

Top module: `rs_sym_fixer`

## Requirements
- R1: After reset, busy, done, fail and fixed_cnt are all 0.
- R2: When idle, host_we writes host_wdata at host_addr. host_rdata shows the byte at the host_addr of the previous cycle. Data byte j is at address j and spare byte k is at address 2048+k.
- R3: For an odd position p from 1 to 1374, the byte at address floor(3p/2) is XORed with pattern bits 11:4, and the upper nibble of the byte at floor(3p/2)+1 is XORed with pattern bits 3:0. This covers p=1365, which updates data byte 2047 and spare byte 0.
- R4: For an even position p from 2 to 1374, the lower nibble of the byte at floor(3p/2)-1 is XORed with pattern bits 11:8, and the byte at floor(3p/2) is XORed with pattern bits 7:0.
- R5: For position 0, a pattern of at most 0xFF is XORed into byte 0. A pattern above 0xFF makes the page uncorrectable.
- R6: A position above 1374 makes the page uncorrectable.
- R7: When a pair is uncorrectable, the pairs before it stay applied. That pair and all later pairs change nothing, and the run ends with fail=1 and fixed_cnt=0.
- R8: Pair i is taken from err_pos[11i+10:11i] and err_pat[12i+11:12i]. Pairs are applied in index order, and each byte update is a read followed by a write, so pairs that touch the same byte both take effect.
- R9: done is high for exactly one cycle when a run ends. After a successful run, fail=0 and fixed_cnt equals err_cnt.
- R10: err_cnt=0 ends the run with no change and fixed_cnt=0. An err_cnt above 4 ends the run with fail=1 and no change.
- R11: While busy is high, start, host writes and changes on err_cnt, err_pos and err_pat have no effect. The pairs are captured in the cycle start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the presented pairs (ignored while busy) |
| err_cnt | input | 3 | Number of pairs to apply |
| err_pos | input | 44 | Four packed 11-bit symbol positions |
| err_pat | input | 48 | Four packed 12-bit error patterns |
| host_we | input | 1 | Host byte write enable (ignored while busy) |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Last run found an uncorrectable pair |
| fixed_cnt | output | 3 | Symbols corrected by the last run |

## Verification
The bench uses the default parameters: a 2048-byte data area, a 64-byte spare area, 14 check bytes and four pairs per page. Positions therefore run from 0 to 1374, and the RAM depth is 2112. These values make the straddling symbol 1365, the last symbol 1374, the first rejected position 1375 and the largest 11-bit position reachable with directed stimulus. Random pairs, including positions past the end, are checked against a bit-level packing model, and after every run the bench reads back the whole RAM.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;
  localparam int SYM_W = 12;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_RDA,
    S_WRA,
    S_RDB,
    S_WRB,
    S_END
  } fix_state_e;
endpackage

// File: rtl/rsfix_ram.sv
module rsfix_ram #(
  parameter int DEPTH = 2112,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  // read-first single port, inferable as block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rsfix_map.sv
module rsfix_map #(
  parameter int POS_W    = 11,
  parameter int AW       = 12,
  parameter int LAST_POS = 1374
) (
  input  logic [POS_W-1:0]           pos,
  input  logic [rsfix_pkg::SYM_W-1:0] pat,
  output logic                       bad,
  output logic                       two,
  output logic [AW-1:0]              addr_a,
  output logic [AW-1:0]              addr_b,
  output logic [7:0]                 mask_a,
  output logic [7:0]                 mask_b
);
  logic [POS_W+1:0] tri3;
  logic [POS_W:0]   half;

  always_comb begin
    tri3   = {2'b00, pos} + {1'b0, pos, 1'b0};
    half   = tri3[POS_W+1:1];
    bad    = 1'b0;
    two    = 1'b0;
    addr_a = '0;
    addr_b = '0;
    mask_a = '0;
    mask_b = '0;
    if (pos == '0) begin
      bad    = |pat[11:8];
      mask_a = pat[7:0];
    end else if (pos > LAST_POS) begin
      bad = 1'b1;
    end else if (pos[0]) begin
      two    = 1'b1;
      addr_a = AW'(half);
      addr_b = AW'(half + 1'b1);
      mask_a = pat[11:4];
      mask_b = {pat[3:0], 4'h0};
    end else begin
      two    = 1'b1;
      addr_a = AW'(half - 1'b1);
      addr_b = AW'(half);
      mask_a = {4'h0, pat[11:8]};
      mask_b = pat[7:0];
    end
  end
endmodule

// File: rtl/rsfix_seq.sv
module rsfix_seq
  import rsfix_pkg::*;
#(
  parameter int MAX_ERR = 4,
  parameter int AW      = 12,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             accept,
  output logic [CNT_W-1:0] idx,
  input  logic             sel_bad,
  input  logic             sel_two,
  input  logic [AW-1:0]    sel_addr_a,
  input  logic [AW-1:0]    sel_addr_b,
  input  logic [7:0]       sel_mask_a,
  input  logic [7:0]       sel_mask_b,
  input  logic [7:0]       ram_q,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [7:0]       ram_wdata,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] fixed_cnt
);
  fix_state_e       st;
  logic [CNT_W-1:0] cnt_r;
  logic [AW-1:0]    a_addr, b_addr;
  logic [7:0]       a_mask, b_mask;
  logic             two_r, fail_pend;

  assign accept    = (st == S_IDLE) && start;
  assign ram_we    = (st == S_WRA) || (st == S_WRB);
  assign ram_addr  = (st == S_RDB || st == S_WRB) ? b_addr : a_addr;
  assign ram_wdata = ram_q ^ ((st == S_WRB) ? b_mask : a_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      cnt_r     <= '0;
      a_addr    <= '0;
      b_addr    <= '0;
      a_mask    <= '0;
      b_mask    <= '0;
      two_r     <= 1'b0;
      fail_pend <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fixed_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cnt_r <= cnt_in;
          idx   <= '0;
          busy  <= 1'b1;
          if (cnt_in > MAX_ERR) begin
            fail_pend <= 1'b1;
            st        <= S_END;
          end else begin
            fail_pend <= 1'b0;
            st        <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (idx == cnt_r) begin
            st <= S_END;
          end else if (sel_bad) begin
            fail_pend <= 1'b1;
            st        <= S_END;
          end else begin
            a_addr <= sel_addr_a;
            b_addr <= sel_addr_b;
            a_mask <= sel_mask_a;
            b_mask <= sel_mask_b;
            two_r  <= sel_two;
            st     <= S_RDA;
          end
        end
        S_RDA: st <= S_WRA;
        S_WRA: begin
          if (two_r) st <= S_RDB;
          else begin
            idx <= idx + 1'b1;
            st  <= S_EVAL;
          end
        end
        S_RDB: st <= S_WRB;
        S_WRB: begin
          idx <= idx + 1'b1;
          st  <= S_EVAL;
        end
        S_END: begin
          done      <= 1'b1;
          busy      <= 1'b0;
          fail      <= fail_pend;
          fixed_cnt <= fail_pend ? '0 : idx;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_ok_count: assert property (@(posedge clk) disable iff (rst)
    (done && !fail) |-> (fixed_cnt == cnt_r));

  a_r8_read_before_write: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (!$past(ram_we) && ($past(ram_addr) == ram_addr)));

  a_r11_writes_in_run: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);

  a_r11_run_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  a_r3_adjacent_bytes: assert property (@(posedge clk) disable iff (rst)
    (st == S_EVAL && idx != cnt_r && !sel_bad && sel_two)
      |-> (sel_addr_b == sel_addr_a + 1'b1));

  a_r7_stop_on_bad: assert property (@(posedge clk) disable iff (rst)
    (st == S_EVAL && idx != cnt_r && sel_bad) |=> (st == S_END && !ram_we));
endmodule

// File: rtl/rs_sym_fixer.sv
module rs_sym_fixer #(
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int ECC_BYTES   = 14,
  parameter int MAX_ERR     = 4,
  parameter int POS_W       = 11,
  localparam int SW         = rsfix_pkg::SYM_W,
  localparam int DEPTH      = DATA_BYTES + SPARE_BYTES,
  localparam int AW         = $clog2(DEPTH),
  localparam int LAST_POS   = ((DATA_BYTES + ECC_BYTES) * 8 + 4) / SW - 1,
  localparam int CNT_W      = $clog2(MAX_ERR + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [CNT_W-1:0]         err_cnt,
  input  logic [MAX_ERR*POS_W-1:0] err_pos,
  input  logic [MAX_ERR*SW-1:0]    err_pat,
  input  logic                     host_we,
  input  logic [AW-1:0]            host_addr,
  input  logic [7:0]               host_wdata,
  output logic [7:0]               host_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     fail,
  output logic [CNT_W-1:0]         fixed_cnt
);
  logic             accept;
  logic [CNT_W-1:0] idx, sel_i;
  logic             m_bad  [MAX_ERR];
  logic             m_two  [MAX_ERR];
  logic [AW-1:0]    m_aa   [MAX_ERR];
  logic [AW-1:0]    m_ab   [MAX_ERR];
  logic [7:0]       m_ma   [MAX_ERR];
  logic [7:0]       m_mb   [MAX_ERR];
  logic             seq_we, ram_we;
  logic [AW-1:0]    seq_addr, ram_addr;
  logic [7:0]       seq_wdata, ram_wdata, ram_q;

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_pair
    logic [POS_W-1:0] pos_q;
    logic [SW-1:0]    pat_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        pos_q <= '0;
        pat_q <= '0;
      end else if (accept) begin
        pos_q <= err_pos[g*POS_W +: POS_W];
        pat_q <= err_pat[g*SW +: SW];
      end
    end

    rsfix_map #(.POS_W(POS_W), .AW(AW), .LAST_POS(LAST_POS)) u_map (
      .pos(pos_q), .pat(pat_q), .bad(m_bad[g]), .two(m_two[g]),
      .addr_a(m_aa[g]), .addr_b(m_ab[g]), .mask_a(m_ma[g]), .mask_b(m_mb[g])
    );
  end

  assign sel_i = (idx < MAX_ERR) ? idx : '0;

  rsfix_seq #(.MAX_ERR(MAX_ERR), .AW(AW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cnt_in(err_cnt),
    .accept(accept), .idx(idx),
    .sel_bad(m_bad[sel_i]), .sel_two(m_two[sel_i]),
    .sel_addr_a(m_aa[sel_i]), .sel_addr_b(m_ab[sel_i]),
    .sel_mask_a(m_ma[sel_i]), .sel_mask_b(m_mb[sel_i]),
    .ram_q(ram_q), .ram_we(seq_we), .ram_addr(seq_addr), .ram_wdata(seq_wdata),
    .busy(busy), .done(done), .fail(fail), .fixed_cnt(fixed_cnt)
  );

  assign ram_we    = busy ? seq_we    : host_we;
  assign ram_addr  = busy ? seq_addr  : host_addr;
  assign ram_wdata = busy ? seq_wdata : host_wdata;

  rsfix_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_q)
  );

  assign host_rdata = ram_q;
endmodule

// File: tb/sim_rs_sym_fixer.sv
`timescale 1ns/1ps
module sim_rs_sym_fixer;
  localparam int DEPTH = 2112;
  localparam int LAST  = 1374;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  err_cnt = '0;
  logic [43:0] err_pos = '0;
  logic [47:0] err_pat = '0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        busy, done, fail;
  logic [2:0]  fixed_cnt;

  logic [7:0]  model [DEPTH];
  int          tp [4];
  logic [11:0] tq [4];
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;

  rs_sym_fixer u0 (
    .clk(clk), .rst(rst), .start(start), .err_cnt(err_cnt),
    .err_pos(err_pos), .err_pat(err_pat), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .done(done), .fail(fail), .fixed_cnt(fixed_cnt)
  );

  always #4 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit sym_bad(input int p, input logic [11:0] q);
    return (p > LAST) || (p == 0 && q > 12'h0FF);
  endfunction

  // bit-level packing model: symbol p starts at page bit 12p-4, msb first
  task automatic ref_apply(input int p, input logic [11:0] q);
    for (int k = 11; k >= 0; k--) begin
      int g;
      g = 12 * p - 4 + (11 - k);
      if (g >= 0) model[g / 8][7 - (g % 8)] = model[g / 8][7 - (g % 8)] ^ q[k];
    end
  endtask

  task automatic compare_page(input string req);
    int bad_n;
    int first_a;
    logic [7:0] first_act;
    bad_n = 0;
    first_a = 0;
    first_act = '0;
    for (int a = 0; a <= DEPTH; a++) begin
      @(negedge clk);
      if (a > 0 && host_rdata !== model[a - 1]) begin
        if (bad_n == 0) begin
          first_a = a - 1;
          first_act = host_rdata;
        end
        bad_n++;
      end
      if (a < DEPTH) host_addr = 12'(a);
    end
    chk(bad_n == 0, req, $sformatf("page byte %0d", first_a),
        int'(first_act), int'(model[first_a]));
  endtask

  task automatic run_fix(input int cnt, input string req, input bit meddle);
    int exp_fail;
    bit seen;
    int got_fail;
    int got_cnt;
    exp_fail = 0;
    if (cnt > 4) exp_fail = 1;
    else begin
      for (int i = 0; i < cnt; i++) begin
        if (sym_bad(tp[i], tq[i])) begin
          exp_fail = 1;
          break;
        end
        ref_apply(tp[i], tq[i]);
      end
    end
    @(negedge clk);
    start = 1'b1;
    err_cnt = 3'(cnt);
    for (int i = 0; i < 4; i++) begin
      err_pos[i*11 +: 11] = 11'(tp[i]);
      err_pat[i*12 +: 12] = tq[i];
    end
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    got_fail = 0;
    got_cnt = 0;
    for (int w = 0; w < 400 && !seen; w++) begin
      if (done) begin
        seen = 1'b1;
        got_fail = int'(fail);
        got_cnt = int'(fixed_cnt);
      end else begin
        if (meddle && w == 0) begin
          chk(busy, "R11", "busy during run", int'(busy), 1);
          host_we = 1'b1;
          host_addr = 12'd100;
          host_wdata = ~model[100];
          start = 1'b1;
          err_cnt = 3'd4;
          err_pos = '0;
          err_pat = {48{1'b1}};
        end
        @(negedge clk);
        host_we = 1'b0;
        start = 1'b0;
      end
    end
    chk(seen, req, "done seen", int'(seen), 1);
    chk(got_fail == exp_fail, req, "fail flag", got_fail, exp_fail);
    chk(got_cnt == (exp_fail != 0 ? 0 : cnt), req, "fixed_cnt", got_cnt,
        exp_fail != 0 ? 0 : cnt);
    @(negedge clk);
    chk(!done, "R9", "done one cycle", int'(done), 0);
    compare_page(req);
  endtask

  task automatic set_pair(input int i, input int p, input logic [11:0] q);
    tp[i] = p;
    tq[i] = q;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) set_pair(i, 0, 12'h000);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !fail && fixed_cnt == 0, "R1", "reset outputs",
        int'({busy, done, fail, fixed_cnt}), 0);

    // load a random page through the host port
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = 8'($urandom);
      host_we = 1'b1;
      host_addr = 12'(a);
      host_wdata = model[a];
      @(negedge clk);
    end
    host_we = 1'b0;
    host_addr = 12'd2053;
    @(negedge clk);
    chk(host_rdata == model[2053], "R2", "spare byte 5 readback",
        int'(host_rdata), int'(model[2053]));
    compare_page("R2");

    run_fix(0, "R10", 1'b0);

    set_pair(0, 0, 12'h0A5);
    run_fix(1, "R5", 1'b0);
    set_pair(0, 0, 12'h1A5);
    run_fix(1, "R5", 1'b0);

    set_pair(0, 1, 12'hB3C);
    run_fix(1, "R3", 1'b0);
    set_pair(0, 2, 12'h5E7);
    run_fix(1, "R4", 1'b0);
    set_pair(0, 1365, 12'hFFF);
    run_fix(1, "R3", 1'b0);

    set_pair(0, 1366, 12'h9A1);
    set_pair(1, 1373, 12'h3C5);
    set_pair(2, 1374, 12'hE0F);
    run_fix(3, "R4", 1'b0);

    set_pair(0, 1375, 12'h001);
    run_fix(1, "R6", 1'b0);
    set_pair(0, 2047, 12'h800);
    run_fix(1, "R6", 1'b0);

    set_pair(0, 7, 12'hABC);
    set_pair(1, 8, 12'h123);
    set_pair(2, 9, 12'h5A5);
    set_pair(3, 9, 12'h5A5);
    run_fix(4, "R8", 1'b0);

    set_pair(0, 10, 12'h777);
    set_pair(1, 1400, 12'h111);
    set_pair(2, 20, 12'h222);
    run_fix(3, "R7", 1'b0);
    set_pair(0, 30, 12'h0F0);
    set_pair(1, 0, 12'h300);
    run_fix(2, "R7", 1'b0);

    set_pair(0, 40, 12'h444);
    run_fix(5, "R10", 1'b0);

    set_pair(0, 1000, 12'h6D2);
    set_pair(1, 1001, 12'h2B9);
    run_fix(2, "R11", 1'b1);

    set_pair(0, 500, 12'hC01);
    set_pair(1, 3, 12'h0FE);
    set_pair(2, 1200, 12'h7A7);
    set_pair(3, 0, 12'h0FF);
    run_fix(4, "R9", 1'b0);

    for (int t = 0; t < 12; t++) begin
      int n;
      n = 1 + int'($urandom_range(3));
      for (int i = 0; i < 4; i++) begin
        int p;
        if ($urandom_range(7) == 0) p = int'($urandom_range(2047));
        else p = int'($urandom_range(LAST));
        set_pair(i, p, 12'($urandom));
      end
      run_fix(n, "R8", 1'b0);
    end

    summary();
    $finish;
  end
endmodule